// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block steps a programmable logic device from power-up to user operation. After reset it pulls the shared open-drain, active-low init line low while the configuration memory is being cleared. It then releases the line and waits. If anything outside still holds the line low, the sequence stalls. Once the line is sensed high, configuration data is accepted. A device set as master first waits an extra, parameterised number of cycles.

While data is loading, an error strobe makes the block pull the init line low again and latch an error state. Only reset clears that state. A load-complete strobe instead ends configuration. The active-low status output is then released, the user-mode enable is raised, and the pins that were held tri-stated are handed to user logic.

The sensed init level passes through a two-flop synchronizer before the state machine uses it. All outputs are decoded directly from the state register.

Top module: `cfg_startup_seq`

## Requirements
- R1: While reset is asserted, and after reset until `mem_clear_done` is seen high, `init_pull`=1, `status_n`=0, `cfg_accept`=0, `user_mode`=0 and `io_float`=1.
- R2: On the clock edge that samples `mem_clear_done` high during clearing, `init_pull` drops to 0. While `init_sense` stays low after that, `cfg_accept` stays 0.
- R3: With `master_mode`=0, `cfg_accept` rises right after the third rising edge that follows `init_sense` going high. Two of those edges are the synchronizer.
- R4: With `master_mode`=1, that latency grows by exactly `DELAY_CYC` cycles.
- R5: If `init_sense` falls during the master delay, the block returns to waiting with `cfg_accept`=0. A later rise of the line restarts the full delay.
- R6: `data_err` sampled high while `cfg_accept`=1 sets `init_pull`=1 and `cfg_accept`=0 from the next cycle, with `status_n` kept at 0. This holds even when `load_done` is high in the same cycle.
- R7: The error state is sticky until reset. Later `load_done` or `data_err` pulses leave `init_pull`=1 and `status_n`=0.
- R8: `load_done` sampled high while `cfg_accept`=1 and `data_err`=0 sets `status_n`=1, `user_mode`=1 and `io_float`=0, with `cfg_accept`=0 and `init_pull`=0, from the next cycle.
- R9: After completion, `data_err` pulses and low levels on `init_sense` change no output.
- R10: `data_err` and `load_done` have no effect while configuration is not yet being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_clear_done | input | 1 | Configuration memory clearing has finished |
| master_mode | input | 1 | 1 selects master mode (extra delay) |
| init_sense | input | 1 | Sensed level of the init line |
| data_err | input | 1 | Configuration data error strobe |
| load_done | input | 1 | Configuration load complete strobe |
| init_pull | output | 1 | 1 drives the open-drain init line low |
| status_n | output | 1 | Active-low configuration status; 1 when complete |
| cfg_accept | output | 1 | Configuration data may be accepted |
| user_mode | output | 1 | Device is in user operation |
| io_float | output | 1 | Unused outputs tri-stated with weak pull-up |

## Verification
A wrong state shows at the ports within one cycle. Every output is a decode of the state, so a missed or extra transition flips `init_pull`, `cfg_accept` or `status_n` right after the edge that caused it. Timing faults in the synchronizer or the delay counter show as a shift in the cycle at which `cfg_accept` rises. The bench therefore measures that latency exactly in both modes, and also after a delay is aborted. Sticky states are probed by applying strobes that must be ignored and confirming that the outputs stay put.

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq #(
  parameter int unsigned DELAY_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_clear_done,
  input  logic master_mode,
  input  logic init_sense,
  input  logic data_err,
  input  logic load_done,
  output logic init_pull,
  output logic status_n,
  output logic cfg_accept,
  output logic user_mode,
  output logic io_float
);
  localparam int unsigned CW = $clog2(DELAY_CYC + 1);

  typedef enum logic [2:0] {
    S_RESET = 3'd0, S_CLEAR = 3'd1, S_WAIT = 3'd2, S_MDLY = 3'd3,
    S_CONFIG = 3'd4, S_ERROR = 3'd5, S_DONE = 3'd6
  } st_t;

  st_t state, state_nx;
  logic sync1, init_s;
  logic [CW-1:0] cnt;
  logic cnt_last;

  assign cnt_last = (cnt == CW'(DELAY_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b0;
      init_s <= 1'b0;
    end else begin
      sync1  <= init_sense;
      init_s <= sync1;
    end
  end

  always_comb begin
    state_nx = state;
    case (state)
      S_RESET:  state_nx = S_CLEAR;
      S_CLEAR:  if (mem_clear_done) state_nx = S_WAIT;
      S_WAIT:   if (init_s) state_nx = master_mode ? S_MDLY : S_CONFIG;
      S_MDLY:   if (!init_s) state_nx = S_WAIT;
                else if (cnt_last) state_nx = S_CONFIG;
      S_CONFIG: if (data_err) state_nx = S_ERROR;
                else if (load_done) state_nx = S_DONE;
      default:  state_nx = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RESET;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      if (state == S_MDLY && state_nx == S_MDLY) cnt <= cnt + 1'b1;
      else cnt <= '0;
    end
  end

  assign init_pull  = (state == S_RESET) || (state == S_CLEAR) || (state == S_ERROR);
  assign cfg_accept = (state == S_CONFIG);
  assign user_mode  = (state == S_DONE);
  assign status_n   = user_mode;
  assign io_float   = ~user_mode;
endmodule

module cfg_startup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_clear_done,
  input logic       init_sense,
  input logic       data_err,
  input logic       load_done,
  input logic       init_pull,
  input logic       status_n,
  input logic       cfg_accept,
  input logic       user_mode,
  input logic [2:0] state
);
  localparam logic [2:0] ERR_CODE = 3'd5;

  p_clear_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_pull) |-> $past(mem_clear_done));

  p_line_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_accept) |-> $past(init_sense, 3));

  p_err_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_accept && data_err) |=> (init_pull && !cfg_accept && !status_n));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ERR_CODE) |=> (state == ERR_CODE && !status_n && init_pull));

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_n) |-> ($past(load_done) && $past(cfg_accept) && !$past(data_err)));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |=> (user_mode && status_n && !init_pull && !cfg_accept));
endmodule

bind cfg_startup_seq cfg_startup_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_clear_done(mem_clear_done),
  .init_sense(init_sense), .data_err(data_err), .load_done(load_done),
  .init_pull(init_pull), .status_n(status_n), .cfg_accept(cfg_accept),
  .user_mode(user_mode), .state(state)
);

// File: tb/cfg_startup_seq_tb_top.sv
`timescale 1ns/1ps
module cfg_startup_seq_tb_top;
  localparam int unsigned D = 8;

  logic clk = 1'b0;
  logic rst_n, mem_clear_done, master_mode, ext_hold, data_err, load_done;
  logic init_pull, status_n, cfg_accept, user_mode, io_float;
  logic init_sense;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  // open-drain init line with pull-up: low if the block or anything outside pulls it
  assign init_sense = ~init_pull & ~ext_hold;

  cfg_startup_seq #(.DELAY_CYC(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_clear_done(mem_clear_done),
    .master_mode(master_mode), .init_sense(init_sense), .data_err(data_err),
    .load_done(load_done), .init_pull(init_pull), .status_n(status_n),
    .cfg_accept(cfg_accept), .user_mode(user_mode), .io_float(io_float)
  );

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pull,stat_n,acc,user,float} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {init_pull, status_n, cfg_accept, user_mode, io_float};
  endfunction

  task automatic do_reset(logic m);
    @(negedge clk);
    rst_n = 1'b0; ext_hold = 1'b1; mem_clear_done = 1'b0;
    master_mode = m; data_err = 1'b0; load_done = 1'b0;
    #1 chk("R1 in reset", outs(), 5'b10001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_clear();
    @(negedge clk) mem_clear_done = 1'b1;
    @(negedge clk) mem_clear_done = 1'b0;
  endtask

  task automatic measure(output int n);
    @(negedge clk) ext_hold = 1'b0;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (cfg_accept) break;
    end
  endtask

  task automatic t_reset_clear();
    do_reset(1'b0);
    repeat (5) @(negedge clk);
    chk("R1 clearing holds", outs(), 5'b10001);
    do_clear();
    chk("R2 release after clear", outs(), 5'b00001);
    repeat (20) @(negedge clk);
    chk("R2 held low stays waiting", outs(), 5'b00001);
  endtask

  task automatic t_ignored_before_config();
    @(negedge clk) data_err = 1'b1; load_done = 1'b1;
    @(negedge clk) data_err = 1'b0; load_done = 1'b0;
    chk("R10 strobes in wait", outs(), 5'b00001);
    @(negedge clk);
    chk("R10 strobes in wait later", outs(), 5'b00001);
  endtask

  task automatic t_slave_latency();
    int n;
    measure(n);
    chk_int("R3 slave latency", n, 3);
    chk("R3 accepting", outs(), 5'b00101);
  endtask

  task automatic t_master_latency();
    int n;
    do_reset(1'b1);
    do_clear();
    measure(n);
    chk_int("R4 master latency", n, 3 + D);
  endtask

  task automatic t_master_abort();
    int n;
    do_reset(1'b1);
    do_clear();
    @(negedge clk) ext_hold = 1'b0;
    repeat (5) @(negedge clk);
    ext_hold = 1'b1;
    repeat (D + 6) @(negedge clk);
    chk("R5 back to wait", outs(), 5'b00001);
    measure(n);
    chk_int("R5 full delay restart", n, 3 + D);
  endtask

  task automatic t_error();
    do_reset(1'b0);
    do_clear();
    begin int n; measure(n); end
    data_err = 1'b1; load_done = 1'b1;
    @(negedge clk) data_err = 1'b0; load_done = 1'b0;
    chk("R6 error wins", outs(), 5'b10001);
    @(negedge clk) load_done = 1'b1;
    @(negedge clk) load_done = 1'b0; data_err = 1'b1;
    @(negedge clk) data_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 error sticky", outs(), 5'b10001);
  endtask

  task automatic t_done();
    do_reset(1'b0);
    do_clear();
    begin int n; measure(n); end
    load_done = 1'b1;
    @(negedge clk) load_done = 1'b0;
    chk("R8 complete", outs(), 5'b01010);
    data_err = 1'b1; ext_hold = 1'b1;
    @(negedge clk) data_err = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 done ignores err and line", outs(), 5'b01010);
    ext_hold = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ext_hold = 1'b1; mem_clear_done = 1'b0;
    master_mode = 1'b0; data_err = 1'b0; load_done = 1'b0;
    t_reset_clear();
    t_ignored_before_config();
    t_slave_latency();
    t_master_latency();
    t_master_abort();
    t_error();
    t_done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule